// File: doc/BRIEF.md
# Accumulator Load Sign-Extension Unit

This block is the register-write path for a pair of 40-bit accumulators, the two auxiliary register pairs and the status register of a small fixed-point processor. Each accumulator is kept as three 16-bit words: a high word, a middle word and a low word. Register writes arrive one per cycle. Each write carries a destination register number, a 16-bit value and a kind code. The kind code separates plain moves, full-width loads and short immediate loads.

The block applies one rule. When the status-register mode bit selects 40-bit mode and a load targets an accumulator middle word, the block does three things in the same cycle:
- it stores the value in the middle word;
- it fills the high word with copies of the value's sign bit;
- it clears the low word.

The accumulator then holds the loaded value as a sign-extended 40-bit number. In 16-bit mode, and for non-load moves, only the addressed word changes. Two control pulses set and clear the mode bit. A combinational read port returns any single register, or a whole accumulator packed into 40 bits.

The write interface is valid/ready. `wr_ready` is held high, so the block never applies back-pressure, and a write is taken in every cycle in which `wr_valid` is high. The read port is plain combinational logic with no handshake.

Top module: `acc_load_ext`

## Requirements
- R1: After reset, the status register reads 0x4000, which is 40-bit mode. Every accumulator word and every auxiliary register reads 0.
- R2: A write to register 0x13 stores the full 16-bit value in the status register. Bit 14 of the status register is the mode bit: 1 selects 40-bit mode and 0 selects 16-bit mode.
- R3: A pulse on `set40` sets bit 14 and a pulse on `set16` clears it.
  - If both pulses are high in one cycle, `set40` wins.
  - A pulse decides bit 14 even when a status write happens in the same cycle; the other bits come from the write.
- R4: In 40-bit mode, a load (kind 1, or kind 2 with a middle-word target) to AC0.M (0x1E) or AC1.M (0x1F) does the following:
  - it stores the value in M;
  - it sets H to 0xFFFF when value bit 15 is 1, and to 0x0000 otherwise;
  - it sets L to 0.
- R5: In 16-bit mode, a load to a middle word changes only M.
- R6: A plain write (kind 0 or kind 3) to a middle word changes only M, in either mode.
- R7: A write to a high word (0x10/0x11), a low word (0x1C/0x1D) or an auxiliary register (AXL0/AXL1 at 0x18/0x19, AXH0/AXH1 at 0x1A/0x1B) stores the value in that register only, even for a load in 40-bit mode.
- R8: For a short load (kind 2), the block ignores `wr_reg` and decodes `wr_data` as follows:
  - the destination is 0x18 + `wr_data[10:8]`;
  - the stored value is `wr_data[7:0]` sign-extended to 16 bits;
  - with d = 6 or 7, the destination is a middle word and R4/R5 apply.
- R9: The mode used for a write is the status value held before that write's cycle. A `set16` pulse in the same cycle as a load does not stop that load's extension.
- R10: The read port returns values as follows:
  - `rd_acc` returns {H[7:0], M, L} of the accumulator chosen by `rd_acc_sel`;
  - `rd_data` returns the register numbered `rd_reg` for 0x10, 0x11, 0x13 and 0x18 to 0x1F, and 0 for any other number.
- R11: `wr_ready` is always 1. A write to any register number not listed above changes no readable state. Every accepted write is visible on the read port from the cycle after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write accept, always 1 |
| wr_kind | input | 2 | 0 plain, 1 load, 2 short load, 3 plain |
| wr_reg | input | 5 | Destination register number |
| wr_data | input | 16 | Write value; for a short load, the opcode word |
| set40 | input | 1 | Pulse: set the mode bit (40-bit mode) |
| set16 | input | 1 | Pulse: clear the mode bit (16-bit mode) |
| rd_reg | input | 5 | Register number for the read port |
| rd_data | output | 16 | Selected register value |
| rd_acc_sel | input | 1 | Accumulator select for `rd_acc` |
| rd_acc | output | 40 | Packed accumulator {H[7:0], M, L} |

## Verification
Every write, including the neighbour words it rewrites, is captured at the rising edge that accepts it. It is therefore due on the read port one cycle later. The mode pulses take effect on that same edge. A write and a pulse in one cycle still use the mode held before that edge.

The bench drives each request on a falling edge, keeps it for one full cycle and drops it on the next falling edge. It reads the combinational read port half a cycle after the capturing edge, so every check samples exactly the first cycle in which the result is due. The mode ordering check puts a `set16` pulse in the same cycle as a middle-word load and expects the extension plus a cleared mode bit in the next cycle.

// File: rtl/acc_ext_pkg.sv
package acc_ext_pkg;
  // Register numbers that set the block's behaviour
  localparam int ACH_BASE = 16; // high words 0x10, 0x11
  localparam int SR_NUM   = 19; // status register 0x13
  localparam int AXL_BASE = 24; // AXL0, AXL1, AXH0, AXH1 at 0x18..0x1B
  localparam int ACL_BASE = 28; // low words 0x1C, 0x1D
  localparam int ACM_BASE = 30; // middle words 0x1E, 0x1F

  typedef enum logic [1:0] {
    WK_PLAIN = 2'd0,
    WK_LOAD  = 2'd1,
    WK_SHORT = 2'd2,
    WK_ALT   = 2'd3
  } wr_kind_e;
endpackage

// File: rtl/acc_wr_decode.sv
module acc_wr_decode
  import acc_ext_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int REG_W   = 5,
  parameter int IMM_W   = 8,
  parameter int SEL_LSB = 8,
  parameter int SEL_W   = 3
) (
  input  logic [1:0]        kind,
  input  logic [REG_W-1:0]  reg_in,
  input  logic [DATA_W-1:0] data_in,
  output logic [REG_W-1:0]  tgt_reg,
  output logic [DATA_W-1:0] tgt_data,
  output logic              tgt_load
);
  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] short_val;
  logic [REG_W-1:0]  short_reg;

  assign short_val = {{EXT_W{data_in[IMM_W-1]}}, data_in[IMM_W-1:0]};
  assign short_reg = REG_W'(AXL_BASE) + REG_W'(data_in[SEL_LSB +: SEL_W]);

  always_comb begin
    tgt_reg  = reg_in;
    tgt_data = data_in;
    tgt_load = 1'b0;
    unique case (wr_kind_e'(kind))
      WK_LOAD:  tgt_load = 1'b1;
      WK_SHORT: begin
        tgt_reg  = short_reg;
        tgt_data = short_val;
        tgt_load = 1'b1;
      end
      default:  tgt_load = 1'b0;
    endcase
  end
endmodule

// File: rtl/acc_mode_reg.sv
module acc_mode_reg #(
  parameter int              DATA_W    = 16,
  parameter int              MODE_BIT  = 14,
  parameter logic [DATA_W-1:0] RESET_VAL = 16'h4000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              set40,
  input  logic              set16,
  output logic [DATA_W-1:0] sr_q,
  output logic              mode40
);
  logic [DATA_W-1:0] sr_n;

  always_comb begin
    sr_n = sr_q;
    if (wr_en) sr_n = wr_data;
    if (set40)      sr_n[MODE_BIT] = 1'b1;
    else if (set16) sr_n[MODE_BIT] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= RESET_VAL;
    else        sr_q <= sr_n;
  end

  assign mode40 = sr_q[MODE_BIT];
endmodule

// File: rtl/acc_word_bank.sv
module acc_word_bank
  import acc_ext_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int REG_W  = 5,
  parameter int IDX    = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  tgt_reg,
  input  logic [DATA_W-1:0] tgt_data,
  input  logic              ext_ok,
  output logic [DATA_W-1:0] h_q,
  output logic [DATA_W-1:0] m_q,
  output logic [DATA_W-1:0] l_q
);
  localparam logic [REG_W-1:0] NUM_H = REG_W'(ACH_BASE + IDX);
  localparam logic [REG_W-1:0] NUM_M = REG_W'(ACM_BASE + IDX);
  localparam logic [REG_W-1:0] NUM_L = REG_W'(ACL_BASE + IDX);

  logic hit_h, hit_m, hit_l, ext;

  assign hit_h = wr_en && (tgt_reg == NUM_H);
  assign hit_m = wr_en && (tgt_reg == NUM_M);
  assign hit_l = wr_en && (tgt_reg == NUM_L);
  assign ext   = hit_m && ext_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q <= '0;
      m_q <= '0;
      l_q <= '0;
    end else begin
      if (hit_h) h_q <= tgt_data;
      if (hit_m) m_q <= tgt_data;
      if (hit_l) l_q <= tgt_data;
      if (ext) begin
        h_q <= {DATA_W{tgt_data[DATA_W-1]}};
        l_q <= '0;
      end
    end
  end
endmodule

// File: rtl/acc_load_ext.sv
module acc_load_ext
  import acc_ext_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int REG_W    = 5,
  parameter int ACC_HI_W = 8,
  parameter int NUM_ACC  = 2,
  parameter int NUM_AX   = 4,
  parameter int MODE_BIT = 14
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_valid,
  output logic                                wr_ready,
  input  logic [1:0]                          wr_kind,
  input  logic [REG_W-1:0]                    wr_reg,
  input  logic [DATA_W-1:0]                   wr_data,
  input  logic                                set40,
  input  logic                                set16,
  input  logic [REG_W-1:0]                    rd_reg,
  output logic [DATA_W-1:0]                   rd_data,
  input  logic [$clog2(NUM_ACC)-1:0]          rd_acc_sel,
  output logic [2*DATA_W+ACC_HI_W-1:0]        rd_acc
);
  localparam logic [REG_W-1:0]  NUM_SR   = REG_W'(SR_NUM);
  localparam logic [DATA_W-1:0] SR_RESET = DATA_W'(1) << MODE_BIT;

  logic [REG_W-1:0]  tgt_reg;
  logic [DATA_W-1:0] tgt_data;
  logic              tgt_load;
  logic              wr_en;
  logic [DATA_W-1:0] sr_q;
  logic              mode40;
  logic              ext_ok;

  logic [NUM_ACC-1:0][DATA_W-1:0] bank_h, bank_m, bank_l;
  logic [NUM_AX-1:0][DATA_W-1:0]  ax_q;

  assign wr_ready = 1'b1;
  assign wr_en    = wr_valid && wr_ready;

  acc_wr_decode #(.DATA_W(DATA_W), .REG_W(REG_W)) u_dec (
    .kind     (wr_kind),
    .reg_in   (wr_reg),
    .data_in  (wr_data),
    .tgt_reg  (tgt_reg),
    .tgt_data (tgt_data),
    .tgt_load (tgt_load)
  );

  acc_mode_reg #(.DATA_W(DATA_W), .MODE_BIT(MODE_BIT), .RESET_VAL(SR_RESET)) u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en && (tgt_reg == NUM_SR)),
    .wr_data (tgt_data),
    .set40   (set40),
    .set16   (set16),
    .sr_q    (sr_q),
    .mode40  (mode40)
  );

  assign ext_ok = mode40 && tgt_load;

  for (genvar a = 0; a < NUM_ACC; a++) begin : g_acc
    acc_word_bank #(.DATA_W(DATA_W), .REG_W(REG_W), .IDX(a)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .tgt_reg  (tgt_reg),
      .tgt_data (tgt_data),
      .ext_ok   (ext_ok),
      .h_q      (bank_h[a]),
      .m_q      (bank_m[a]),
      .l_q      (bank_l[a])
    );
  end

  for (genvar x = 0; x < NUM_AX; x++) begin : g_ax
    localparam logic [REG_W-1:0] NUM_X = REG_W'(AXL_BASE + x);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          ax_q[x] <= '0;
      else if (wr_en && tgt_reg == NUM_X)  ax_q[x] <= tgt_data;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_reg == NUM_SR) rd_data = sr_q;
    for (int k = 0; k < NUM_ACC; k++) begin
      if (rd_reg == REG_W'(ACH_BASE + k)) rd_data = bank_h[k];
      if (rd_reg == REG_W'(ACM_BASE + k)) rd_data = bank_m[k];
      if (rd_reg == REG_W'(ACL_BASE + k)) rd_data = bank_l[k];
    end
    for (int k = 0; k < NUM_AX; k++) begin
      if (rd_reg == REG_W'(AXL_BASE + k)) rd_data = ax_q[k];
    end
  end

  assign rd_acc = {bank_h[rd_acc_sel][ACC_HI_W-1:0], bank_m[rd_acc_sel], bank_l[rd_acc_sel]};
endmodule

// File: rtl/acc_load_ext_chk.sv
module acc_load_ext_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_valid,
  input logic [1:0]  wr_kind,
  input logic [4:0]  wr_reg,
  input logic [15:0] wr_data,
  input logic        set40,
  input logic        set16,
  input logic        mode40,
  input logic [15:0] h0,
  input logic [15:0] m0,
  input logic [15:0] l0
);
  AST_EXT_FILL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_kind == 2'd1 && wr_reg == 5'h1E && mode40) |=> (h0 == {16{$past(wr_data[15])}})); // R4
  AST_EXT_CLEAR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_kind == 2'd1 && wr_reg == 5'h1E && mode40) |=> (l0 == 16'h0000)); // R4
  AST_MODE16_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_kind == 2'd1 && wr_reg == 5'h1E && !mode40) |=> (h0 == $past(h0) && l0 == $past(l0))); // R5
  AST_PLAIN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_kind[0] == wr_kind[1] && wr_reg == 5'h1E) |=> (h0 == $past(h0) && l0 == $past(l0))); // R6
  AST_SET40_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    set40 |=> mode40); // R3
  AST_SET16_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (set16 && !set40) |=> !mode40); // R3
  AST_SHORT_MID: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_kind == 2'd2 && wr_data[10:8] == 3'd6) |=> (m0 == {{8{$past(wr_data[7])}}, $past(wr_data[7:0])})); // R8
endmodule

bind acc_load_ext acc_load_ext_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_valid (wr_valid),
  .wr_kind  (wr_kind),
  .wr_reg   (wr_reg),
  .wr_data  (wr_data),
  .set40    (set40),
  .set16    (set16),
  .mode40   (mode40),
  .h0       (bank_h[0]),
  .m0       (bank_m[0]),
  .l0       (bank_l[0])
);

// File: tb/tb_acc_load_ext.sv
module tb_acc_load_ext;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [1:0]  wr_kind = 2'd0;
  logic [4:0]  wr_reg = 5'd0;
  logic [15:0] wr_data = 16'd0;
  logic        set40 = 1'b0;
  logic        set16 = 1'b0;
  logic [4:0]  rd_reg = 5'd0;
  logic [15:0] rd_data;
  logic [0:0]  rd_acc_sel = 1'b0;
  logic [39:0] rd_acc;

  int checks = 0;
  int failures = 0;

  acc_load_ext dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_kind(wr_kind), .wr_reg(wr_reg), .wr_data(wr_data),
    .set40(set40), .set16(set16), .rd_reg(rd_reg), .rd_data(rd_data),
    .rd_acc_sel(rd_acc_sel), .rd_acc(rd_acc)
  );

  always #10 clk = ~clk;

  // {mode40, kind, reg, data, sel, expected packed accumulator}
  // every accumulator is preloaded with H=0x00AB, M=0x1111, L=0x2222 before the write
  localparam int NV = 12;
  localparam logic [64:0] VEC [NV] = '{
    {1'b1, 2'd1, 5'h1E, 16'h1234, 1'b0, 40'h00_1234_0000},  // R4 positive
    {1'b1, 2'd1, 5'h1F, 16'h8001, 1'b1, 40'hFF_8001_0000},  // R4 negative, acc1
    {1'b0, 2'd1, 5'h1E, 16'h8001, 1'b0, 40'hAB_8001_2222},  // R5 negative
    {1'b0, 2'd1, 5'h1F, 16'h7FFF, 1'b1, 40'hAB_7FFF_2222},  // R5 positive
    {1'b1, 2'd0, 5'h1E, 16'h8000, 1'b0, 40'hAB_8000_2222},  // R6 plain move
    {1'b1, 2'd1, 5'h1C, 16'h8000, 1'b0, 40'hAB_1111_8000},  // R7 low word
    {1'b1, 2'd1, 5'h10, 16'hFF80, 1'b0, 40'h80_1111_2222},  // R7 high word
    {1'b1, 2'd2, 5'h00, 16'h0680, 1'b0, 40'hFF_FF80_0000},  // R8 short d=6 negative
    {1'b1, 2'd2, 5'h00, 16'h077F, 1'b1, 40'h00_007F_0000},  // R8 short d=7 positive
    {1'b0, 2'd2, 5'h00, 16'h06FF, 1'b0, 40'hAB_FFFF_2222},  // R8 short in 16-bit mode
    {1'b1, 2'd1, 5'h1A, 16'h8000, 1'b0, 40'hAB_1111_2222},  // R7 aux write
    {1'b1, 2'd1, 5'h1E, 16'h0000, 1'b0, 40'h00_0000_0000}   // R4 zero value
  };

  task automatic chk16(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk40(input string tag, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] k, input logic [4:0] r, input logic [15:0] d,
                    input logic p40, input logic p16);
    @(negedge clk);
    wr_valid = 1'b1; wr_kind = k; wr_reg = r; wr_data = d; set40 = p40; set16 = p16;
    @(negedge clk);
    wr_valid = 1'b0; set40 = 1'b0; set16 = 1'b0;
  endtask

  task automatic rd(input logic [4:0] r, output logic [15:0] v);
    rd_reg = r;
    #1 v = rd_data;
  endtask

  task automatic preload(input logic s);
    wr(2'd0, 5'h10 + 5'(s), 16'h00AB, 1'b0, 1'b0);
    wr(2'd0, 5'h1E + 5'(s), 16'h1111, 1'b0, 1'b0);
    wr(2'd0, 5'h1C + 5'(s), 16'h2222, 1'b0, 1'b0);
  endtask

  initial begin
    #3_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(5'h13, v); chk16("R1 status reset", v, 16'h4000);
    rd_acc_sel = 1'b0; #1 chk40("R1 acc0 reset", rd_acc, 40'h0);
    rd_acc_sel = 1'b1; #1 chk40("R1 acc1 reset", rd_acc, 40'h0);
    rd(5'h1B, v); chk16("R1 aux reset", v, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [64:0] e;
      e = VEC[i];
      wr(2'd0, 5'h13, e[64] ? 16'h4000 : 16'h0000, 1'b0, 1'b0);
      preload(e[40]);
      wr(e[63:62], e[61:57], e[56:41], 1'b0, 1'b0);
      rd_acc_sel = e[40];
      #1 chk40($sformatf("R4/R5/R6/R7/R8 vector %0d", i), rd_acc, e[39:0]);
    end
    rd(5'h1A, v); chk16("R7 aux value stored", v, 16'h8000);
    rd(5'h1E, v); chk16("R10 middle word read", v, 16'h0000);

    // R2 status write and R3 pulses
    wr(2'd0, 5'h13, 16'hBEEF, 1'b0, 1'b0);
    rd(5'h13, v); chk16("R2 status write", v, 16'hBEEF);
    wr(2'd3, 5'h00, 16'h0000, 1'b1, 1'b0);
    rd(5'h13, v); chk16("R3 set40", v, 16'hFEEF);
    wr(2'd3, 5'h00, 16'h0000, 1'b0, 1'b1);
    rd(5'h13, v); chk16("R3 set16", v, 16'hBEEF);
    wr(2'd3, 5'h00, 16'h0000, 1'b1, 1'b1);
    rd(5'h13, v); chk16("R3 both pulses set40 wins", v, 16'hFEEF);
    wr(2'd0, 5'h13, 16'h4001, 1'b0, 1'b1);
    rd(5'h13, v); chk16("R3 pulse over status write", v, 16'h0001);

    // R9 mode taken before the cycle
    wr(2'd0, 5'h13, 16'h4000, 1'b0, 1'b0);
    preload(1'b0);
    wr(2'd1, 5'h1E, 16'h8000, 1'b0, 1'b1);
    rd_acc_sel = 1'b0;
    #1 chk40("R9 extension with same-cycle set16", rd_acc, 40'hFF_8000_0000);
    rd(5'h13, v); chk16("R9 mode cleared after", v, 16'h0000);

    // R8 short load to AXL0
    wr(2'd2, 5'h1F, 16'h00F0, 1'b0, 1'b0);
    rd(5'h18, v); chk16("R8 short load sign-extends", v, 16'hFFF0);
    rd_acc_sel = 1'b1; #1 chk40("R8 short ignores wr_reg", rd_acc, 40'h00_007F_0000);

    // R11 unlisted register and ready
    wr(2'd1, 5'h05, 16'h5555, 1'b0, 1'b0);
    rd(5'h18, v); chk16("R11 other reg leaves aux", v, 16'hFFF0);
    rd(5'h13, v); chk16("R11 other reg leaves status", v, 16'h0000);
    rd_acc_sel = 1'b0; #1 chk40("R11 other reg leaves acc0", rd_acc, 40'hFF_8000_0000);
    rd(5'h05, v); chk16("R10 unlisted read is zero", v, 16'h0000);
    chk16("R11 ready high", {15'd0, wr_ready}, 16'h0001);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule